// File: doc/BRIEF.md
# Shift-Then-Saturate Arithmetic Unit

This unit takes a 32-bit two's-complement operand, shifts it left or arithmetically right by a per-operation amount, and then clamps the shifted value into a range whose bit width is also chosen per operation. The range can be signed (symmetric about zero in the usual two's-complement sense) or unsigned (from zero upward), so a signed value can be squeezed into an unsigned field. The clamp is judged on the shifted value kept at double width, so bits pushed out by a left shift count as overflow and never wrap.

Each operation is issued by raising an execute enable for one cycle, standing in for a condition that has passed. One clock edge later the clamped result and a saturated-this-operation indication appear. A sticky flag collects every saturation until a separate clear input drops it. When the enable is low, nothing the unit owns changes.

Top module: `shift_sat_unit`

## Requirements
- R1: While reset is asserted (rstN low) and after its release, result, satOp and satFlag all read 0.
- R2: The shift acts before the clamp, on the operand sign-extended to 64 bits: shiftRight=0 shifts left by shiftAmt (0 to 31, 0 meaning no shift), shiftRight=1 shifts arithmetically right by shiftAmt; bits leaving the 32-bit field on a left shift count toward saturation.
- R3: With unsignedMode=0 the shifted value is clamped to -2^(n-1)..2^(n-1)-1, where n is satPos limited to the range 1..32 (0 acts as 1, values above 32 act as 32).
- R4: With unsignedMode=1 the shifted value is clamped to 0..2^n-1, where n is satPos limited to 0..31 (values above 31 act as 31); every negative shifted value gives 0, so result bit 31 is always 0.
- R5: Signed mode with satPos=32 and a left shift of 0 returns the operand unchanged and never reports saturation.
- R6: Unsigned mode with satPos=0 returns 0 for every operand; satOp is 1 for a nonzero shifted value and 0 for zero.
- R7: An operation with execEn high at a rising edge updates result and satOp on that edge, so they are valid one cycle after the inputs are presented.
- R8: With execEn low, result, satOp and satFlag hold their values (apart from a requested clear of satFlag).
- R9: satOp is 1 exactly when the clamp changed the shifted value; every such operation sets satFlag to 1, and the unit itself never clears it.
- R10: flagClear high at a rising edge clears satFlag, except when a saturating operation completes on the same edge, in which case satFlag is 1.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| execEn | input | 1 | Issue an operation this cycle |
| operand | input | 32 | Signed value to shift and clamp |
| unsignedMode | input | 1 | 0: signed range, 1: unsigned range |
| satPos | input | 6 | Clamp width n |
| shiftRight | input | 1 | 0: left shift, 1: arithmetic right shift |
| shiftAmt | input | 5 | Shift distance |
| flagClear | input | 1 | Synchronous clear of the sticky flag |
| result | output | 32 | Clamped result of the last operation |
| satOp | output | 1 | Last operation saturated |
| satFlag | output | 1 | Sticky saturation flag |

## Verification
On every cycle the assertions check that an idle cycle leaves the result and the per-operation indication frozen, that a saturating operation always leaves the sticky flag set, that only a clear lowers the flag, that a lone clear does lower it, and that an unsigned result never has its top bit set. The exact clamped values, including the limits of each range, bits lost by a left shift, the pass-through and zero-width corner cases, can only be shown by the bench's scenarios, which compare every result against a model of the requirements, across hand-picked cases and a run of pseudo-random operations.

// File: rtl/shift_sat_pkg.sv
package shift_sat_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic loadOut;   // capture result and per-op indication
    logic setFlag;   // raise sticky flag
    logic clrFlag;   // drop sticky flag
  } satStrobes_t;
endpackage

// File: rtl/shift_sat_datapath.sv
module shift_sat_datapath
  import shift_sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W) + 1,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  satStrobes_t       strobes,
  input  logic [DATA_W-1:0] operand,
  input  logic              unsignedMode,
  input  logic [POS_W-1:0]  satPos,
  input  logic              shiftRight,
  input  logic [AMT_W-1:0]  shiftAmt,
  output logic              satHit,
  output logic [DATA_W-1:0] result,
  output logic              satOp,
  output logic              satFlag
);
  localparam int WIDE_W = 2 * DATA_W;
  localparam logic [POS_W-1:0] MAX_SIGNED   = POS_W'(DATA_W);
  localparam logic [POS_W-1:0] MAX_UNSIGNED = POS_W'(DATA_W - 1);

  logic signed [WIDE_W-1:0] extOp, shifted, hiLim, loLim, clamped;
  logic signed [WIDE_W-1:0] unit1;
  logic        [POS_W-1:0]  effPos;

  assign unit1 = WIDE_W'(1);
  assign extOp = {{DATA_W{operand[DATA_W-1]}}, operand};

  // Full-precision pre-shift.
  always_comb begin
    if (shiftRight) shifted = extOp >>> shiftAmt;
    else            shifted = extOp <<< shiftAmt;
  end

  // Limit the clamp width to the legal window for the mode.
  always_comb begin
    effPos = satPos;
    if (unsignedMode) begin
      if (satPos > MAX_UNSIGNED) effPos = MAX_UNSIGNED;
    end else begin
      if (satPos == '0)              effPos = POS_W'(1);
      else if (satPos > MAX_SIGNED)  effPos = MAX_SIGNED;
    end
  end

  // Range bounds.
  always_comb begin
    if (unsignedMode) begin
      hiLim = (unit1 <<< effPos) - unit1;
      loLim = '0;
    end else begin
      hiLim = (unit1 <<< (effPos - POS_W'(1))) - unit1;
      loLim = -(unit1 <<< (effPos - POS_W'(1)));
    end
  end

  always_comb begin
    satHit  = 1'b1;
    if (shifted > hiLim)      clamped = hiLim;
    else if (shifted < loLim) clamped = loLim;
    else begin
      clamped = shifted;
      satHit  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      satOp  <= 1'b0;
    end else if (strobes.loadOut) begin
      result <= clamped[DATA_W-1:0];
      satOp  <= satHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                satFlag <= 1'b0;
    else if (strobes.setFlag) satFlag <= 1'b1;
    else if (strobes.clrFlag) satFlag <= 1'b0;
  end
endmodule

// File: rtl/shift_sat_ctrl.sv
module shift_sat_ctrl
  import shift_sat_pkg::*;
(
  input  logic        execEn,
  input  logic        flagClear,
  input  logic        satHit,
  output satStrobes_t strobes
);
  // A saturation landing on the same edge as a clear wins.
  always_comb begin
    strobes.loadOut = execEn;
    strobes.setFlag = execEn & satHit;
    strobes.clrFlag = flagClear & ~(execEn & satHit);
  end
endmodule

// File: rtl/shift_sat_unit.sv
module shift_sat_unit
  import shift_sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W) + 1,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              execEn,
  input  logic [DATA_W-1:0] operand,
  input  logic              unsignedMode,
  input  logic [POS_W-1:0]  satPos,
  input  logic              shiftRight,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic              flagClear,
  output logic [DATA_W-1:0] result,
  output logic              satOp,
  output logic              satFlag
);
  satStrobes_t strobes;
  logic        satHit;

  shift_sat_ctrl ctrl_i (
    .execEn(execEn), .flagClear(flagClear), .satHit(satHit), .strobes(strobes)
  );

  shift_sat_datapath #(.DATA_W(DATA_W), .POS_W(POS_W), .AMT_W(AMT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .operand(operand),
    .unsignedMode(unsignedMode), .satPos(satPos), .shiftRight(shiftRight),
    .shiftAmt(shiftAmt), .satHit(satHit), .result(result), .satOp(satOp),
    .satFlag(satFlag)
  );
endmodule

// File: rtl/shift_sat_checker.sv
module shift_sat_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              execEn,
  input logic              unsignedMode,
  input logic              flagClear,
  input logic [DATA_W-1:0] result,
  input logic              satOp,
  input logic              satFlag
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !execEn |=> ($stable(result) && $stable(satOp))); // R8

  AST_FLAG_FOLLOWS_SAT: assert property (@(posedge clk) disable iff (!rstN)
    execEn |=> (!satOp || satFlag)); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !flagClear) |=> satFlag); // R9

  AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !execEn) |=> !satFlag); // R10

  AST_UNSIGNED_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && unsignedMode) |=> !result[DATA_W-1]); // R4

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rstN |-> (result == '0 && !satOp && !satFlag)); // R1
endmodule

bind shift_sat_unit shift_sat_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .execEn(execEn), .unsignedMode(unsignedMode),
  .flagClear(flagClear), .result(result), .satOp(satOp), .satFlag(satFlag)
);

// File: tb/shift_sat_unit_tb_top.sv
`timescale 1ns/1ps
module shift_sat_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        execEn = 1'b0;
  logic [31:0] operand = '0;
  logic        unsignedMode = 1'b0;
  logic [5:0]  satPos = 6'd32;
  logic        shiftRight = 1'b0;
  logic [4:0]  shiftAmt = '0;
  logic        flagClear = 1'b0;
  logic [31:0] result;
  logic        satOp, satFlag;

  int checks = 0;
  int errors = 0;
  logic lastEn = 1'b0;
  logic expFlag = 1'b0;
  logic [31:0] lastRes = '0;
  logic lastSat = 1'b0;

  typedef struct { logic [31:0] res; logic sat; logic flag; string tag; } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;  // 250 MHz

  shift_sat_unit dut_i (
    .clk(clk), .rstN(rstN), .execEn(execEn), .operand(operand),
    .unsignedMode(unsignedMode), .satPos(satPos), .shiftRight(shiftRight),
    .shiftAmt(shiftAmt), .flagClear(flagClear), .result(result),
    .satOp(satOp), .satFlag(satFlag)
  );

  // Reference built from R2..R6.
  function automatic void refOp(input logic [31:0] op, input logic uns,
      input logic [5:0] pos, input logic rgt, input logic [4:0] amt,
      output logic [31:0] res, output logic sat);
    longint v, hi, lo;
    int n;
    v = longint'($signed(op));
    v = rgt ? (v >>> amt) : (v <<< amt);
    if (uns) begin
      n  = (pos > 31) ? 31 : int'(pos);
      hi = (64'sd1 <<< n) - 1;
      lo = 0;
    end else begin
      n  = (pos == 0) ? 1 : ((pos > 32) ? 32 : int'(pos));
      hi = (64'sd1 <<< (n - 1)) - 1;
      lo = -(64'sd1 <<< (n - 1));
    end
    sat = 1'b1;
    if (v > hi)      res = hi[31:0];
    else if (v < lo) res = lo[31:0];
    else begin res = v[31:0]; sat = 1'b0; end
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: presents one operation and pushes its expected outcome.
  task automatic doOp(input string tag, input logic [31:0] op, input logic uns,
      input logic [5:0] pos, input logic rgt, input logic [4:0] amt,
      input logic clr = 1'b0);
    item_t it;
    logic [31:0] r; logic s;
    @(negedge clk);
    refOp(op, uns, pos, rgt, amt, r, s);
    expFlag = s ? 1'b1 : (clr ? 1'b0 : expFlag);
    it.res = r; it.sat = s; it.flag = expFlag; it.tag = tag;
    sbq.push_back(it);
    operand = op; unsignedMode = uns; satPos = pos; shiftRight = rgt;
    shiftAmt = amt; flagClear = clr; execEn = 1'b1;
    @(negedge clk);
    execEn = 1'b0; flagClear = 1'b0;
  endtask

  // Idle cycle with scrambled inputs: outputs must hold (R8), optional clear (R10).
  task automatic idleCycle(input string tag, input logic clr);
    @(negedge clk);
    operand = 32'hDEAD_BEEF; satPos = 6'd3; unsignedMode = ~unsignedMode;
    flagClear = clr; execEn = 1'b0;
    if (clr) expFlag = 1'b0;
    @(negedge clk);
    flagClear = 1'b0;
    check({tag, " R8 result hold"}, result, lastRes);
    check({tag, " R8 satOp hold"}, {31'b0, satOp}, {31'b0, lastSat});
    check({tag, " R10 flag"}, {31'b0, satFlag}, {31'b0, expFlag});
  endtask

  always @(posedge clk) lastEn <= execEn;

  // Monitor: pops one item per completed operation (R7).
  always @(negedge clk) begin
    if (rstN && lastEn) begin
      item_t it;
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 result without pending op actual %h expected none", result);
      end else begin
        it = sbq.pop_front();
        check({it.tag, " result"}, result, it.res);
        check({it.tag, " satOp"}, {31'b0, satOp}, {31'b0, it.sat});
        check({it.tag, " R9 satFlag"}, {31'b0, satFlag}, {31'b0, it.flag});
        lastRes = it.res; lastSat = it.sat;
      end
    end
  end

  initial begin : watchdog
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 32'h0);
    check("R1 reset flags", {30'b0, satOp, satFlag}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {result[31:2] | result[1:0], satOp, satFlag}, 32'h0);

    doOp("R2 R3 lsl4 s16 no sat",  32'h0000_0123, 0, 6'd16, 0, 5'd4);
    doOp("R2 R3 lsl4 s16 high",    32'h0000_1234, 0, 6'd16, 0, 5'd4);
    idleCycle("after high", 1'b1);
    doOp("R3 lsl4 s16 low",        32'hFFFF_F000, 0, 6'd16, 0, 5'd4);
    idleCycle("clear", 1'b1);
    doOp("R2 asr31 s8",            32'h8000_0000, 0, 6'd8, 1, 5'd31);
    doOp("R2 lsl1 shifted-out",    32'h4000_0000, 0, 6'd32, 0, 5'd1);
    doOp("R5 passthrough min",     32'h8000_0000, 0, 6'd32, 0, 5'd0);
    doOp("R5 passthrough max",     32'h7FFF_FFFF, 0, 6'd32, 0, 5'd0);
    idleCycle("clear2", 1'b1);
    doOp("R3 n=1 pos",             32'h0000_0001, 0, 6'd1, 0, 5'd0);
    doOp("R3 n=0 acts as 1",       32'hFFFF_FFFE, 0, 6'd0, 0, 5'd0);
    doOp("R3 n>32 acts as 32",     32'h1234_5678, 0, 6'd40, 0, 5'd0);
    doOp("R4 u7 negative",         32'hFFFF_FFFB, 1, 6'd7, 0, 5'd0);
    doOp("R4 u7 high",             32'h0000_00C8, 1, 6'd7, 0, 5'd0);
    doOp("R4 u7 inside",           32'h0000_0064, 1, 6'd7, 0, 5'd0);
    doOp("R4 u31 top",             32'h7FFF_FFFF, 1, 6'd31, 0, 5'd1);
    doOp("R4 n>31 acts as 31",     32'h8000_0000, 1, 6'd50, 1, 5'd0);
    doOp("R6 u0 nonzero",          32'h0000_0005, 1, 6'd0, 0, 5'd0);
    idleCycle("clear3", 1'b1);
    doOp("R6 u0 zero",             32'h0000_0000, 1, 6'd0, 0, 5'd0);
    idleCycle("R8 idle no clear", 1'b0);
    doOp("R10 clear with sat",     32'h7FFF_0000, 0, 6'd8, 0, 5'd0, 1'b1);
    doOp("R10 clear no sat",       32'h0000_0003, 0, 6'd8, 0, 5'd0, 1'b1);

    for (int i = 0; i < 300; i++) begin
      doOp("R2 R3 R4 R9 random", $urandom, 1'($urandom), 6'($urandom_range(0, 40)),
           1'($urandom), 5'($urandom), 1'($urandom_range(0, 7) == 0));
      if (i % 50 == 0) idleCycle("random idle", 1'b0);
    end

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++; errors++;
      $display("FAIL R7 pending ops actual %0d expected 0", sbq.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule